// File: doc/BRIEF.md
# USB Interrupt Flag Aggregator

This block gathers single-cycle event pulses from a USB serial engine and turns them into interrupt requests for an 8-bit controller. The events fall into two groups. The first group carries frame and transaction events: start of frame, the early end-of-frame warning (raised ten clocks before the next frame is due), the hub control endpoint and the three function endpoints. The second group carries bus power events: function remote wakeup, resume and global suspend. Each group has a status register that latches its events, an enable register, a mask register and its own clearing rule. Each group drives its own request line.

Firmware reaches the block through a byte-wide port with a 3-bit address. Reads are combinational. A write takes effect at the next rising clock edge. A request from the suspend/resume group also sets a latched attention flag that feeds the higher-priority vector. The flag stays set until the vector is taken or firmware writes a one to it. A source raises its request only when its flag is set, its enable bit is 1 and its mask bit is 0. An event that arrives in the same cycle as a clear of the same flag always wins.

Top module: `usb_irq_agg`

## Requirements
- R1: Frame/endpoint status (address 0) latches `fe_evt` bit for bit. The bits are 7 SOF, 6 end-of-frame warning, 3 hub EP0, 2 function EP2, 1 function EP1 and 0 function EP0. Bits 5:4 always read zero, even if their events pulse.
- R2: Frame/endpoint flags are cleared only by writing a 1 to the same bit of the acknowledge register (address 3). A write to address 0 has no effect.
- R3: The acknowledge register always reads 0x00.
- R4: Suspend/resume status (address 4) latches `sr_evt`. The bits are 2 remote wakeup, 1 resume and 0 global suspend; bits 7:3 read zero. Writing a 0 to a bit clears that flag. Writing a 1 leaves the bit unchanged and never sets it.
- R5: `hw_irq` is high exactly when some frame/endpoint flag is set with its enable bit (address 1) at 1 and its mask bit (address 2) at 0.
- R6: `susp_irq` is high exactly when some suspend/resume flag is set with its enable bit (address 5) at 1 and its mask bit (address 6) at 0.
- R7: `int0_flag` rises one clock after `susp_irq` is high. It clears on a cycle with `int0_taken` high, or on a write to address 7 with data bit 0 set. Address 7 reads the flag in bit 0, with all other bits zero.
- R8: A flag stays set when its event, or for `int0_flag` an active `susp_irq`, coincides with a clear of that flag.
- R9: After reset every register, both request lines and `int0_flag` are zero.
- R10: Enable and mask registers read back what was written, with bits outside their group's layout (5:4 for the first group, 7:3 for the second) reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_evt | input | 8 | Frame/endpoint event pulses, status bit layout |
| sr_evt | input | 3 | Suspend/resume event pulses, status bit layout |
| int0_taken | input | 1 | High for one cycle when the higher-priority vector is executed |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| hw_irq | output | 1 | Frame/endpoint request line |
| susp_irq | output | 1 | Suspend/resume request line |
| int0_flag | output | 1 | Latched suspend/resume attention flag |

## Verification
An event or a register write shows in the read data and in the request line one clock edge later. `int0_flag` follows `susp_irq` one edge after that, so it lags an event by two edges. The bench applies its inputs a quarter period after a rising edge. A behavioural model updates on that rising edge from the same inputs. Every output is compared with the model at the following falling edge, so each result is checked in the cycle it is due. Directed reads with fixed expected bytes cover the clearing rules, the reserved bits and the collisions between set and clear.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_FE_STAT = 3'd0,
        A_FE_EN   = 3'd1,
        A_FE_MASK = 3'd2,
        A_FE_ACK  = 3'd3,
        A_SR_STAT = 3'd4,
        A_SR_EN   = 3'd5,
        A_SR_MASK = 3'd6,
        A_INT0    = 3'd7
    } reg_addr_e;

    typedef enum logic {
        CLR_ACK, // write one to a separate acknowledge register
        CLR_WR0  // write zero to the flag itself
    } clr_mode_e;

    typedef struct packed {
        logic [REG_W-1:0] flag;
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] mask;
    } grp_regs_t;

    localparam logic [REG_W-1:0] FE_VALID = 8'hCF;
    localparam logic [REG_W-1:0] SR_VALID = 8'h07;
endpackage

// File: rtl/usb_irq_group.sv
module usb_irq_group
    import usb_irq_pkg::*;
#(
    parameter logic [REG_W-1:0] VALID = '1,
    parameter clr_mode_e        MODE  = CLR_ACK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             sel_stat,
    input  logic             sel_en,
    input  logic             sel_mask,
    input  logic             sel_ack,
    output logic [REG_W-1:0] stat,
    output logic [REG_W-1:0] en,
    output logic [REG_W-1:0] mask,
    output logic             req
);
    localparam logic [REG_W-1:0] USE_ACK = {REG_W{MODE == CLR_ACK}};

    grp_regs_t        q, d;
    logic [REG_W-1:0] clr_ack, clr_wr0, clr;

    // Both clearing paths exist; the parameter keeps only one of them.
    assign clr_ack = (wr_en && sel_ack)  ? wr_data  : '0;
    assign clr_wr0 = (wr_en && sel_stat) ? ~wr_data : '0;
    assign clr     = (clr_ack & USE_ACK) | (clr_wr0 & ~USE_ACK);

    always_comb begin
        d = q;
        // An event in the same cycle as a clear wins.
        d.flag = ((q.flag & ~clr) | evt) & VALID;
        if (wr_en && sel_en)   d.en   = wr_data & VALID;
        if (wr_en && sel_mask) d.mask = wr_data & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stat = q.flag;
    assign en   = q.en;
    assign mask = q.mask;
    assign req  = |(q.flag & q.en & ~q.mask);

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & VALID)) |=> ((q.flag & $past(evt & VALID)) == $past(evt & VALID))); // R8

    generate
        if (MODE == CLR_ACK) begin : g_ack
            AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && sel_ack) |=> ((q.flag & $past(wr_data & ~evt)) == '0)); // R2
        end else begin : g_wr0
            AST_WR0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && sel_stat) |=> ((q.flag & ~$past(wr_data) & ~$past(evt)) == '0)); // R4
        end
    endgenerate
endmodule

// File: rtl/usb_int0_flag.sv
module usb_int0_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic taken,
    input  logic wr_clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (taken || wr_clr) flag_d = 1'b0;
        if (req)             flag_d = 1'b1; // a set beats a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    AST_INT0_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> flag); // R7
    AST_INT0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((taken || wr_clr) && !req) |=> !flag); // R7
endmodule

// File: rtl/usb_irq_agg.sv
module usb_irq_agg
    import usb_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] fe_evt,
    input  logic [2:0]       sr_evt,
    input  logic             int0_taken,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             hw_irq,
    output logic             susp_irq,
    output logic             int0_flag
);
    reg_addr_e        addr;
    logic [REG_W-1:0] fe_stat, fe_en, fe_mask;
    logic [REG_W-1:0] sr_stat, sr_en, sr_mask;
    logic [REG_W-1:0] sr_evt_w;
    logic             int0_wr_clr;

    assign addr     = reg_addr_e'(reg_addr);
    assign sr_evt_w = {{(REG_W-3){1'b0}}, sr_evt};

    usb_irq_group #(.VALID(FE_VALID), .MODE(CLR_ACK)) u_fe (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (fe_evt),
        .wr_en    (reg_wr),
        .wr_data  (reg_wdata),
        .sel_stat (addr == A_FE_STAT),
        .sel_en   (addr == A_FE_EN),
        .sel_mask (addr == A_FE_MASK),
        .sel_ack  (addr == A_FE_ACK),
        .stat     (fe_stat),
        .en       (fe_en),
        .mask     (fe_mask),
        .req      (hw_irq)
    );

    usb_irq_group #(.VALID(SR_VALID), .MODE(CLR_WR0)) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (sr_evt_w),
        .wr_en    (reg_wr),
        .wr_data  (reg_wdata),
        .sel_stat (addr == A_SR_STAT),
        .sel_en   (addr == A_SR_EN),
        .sel_mask (addr == A_SR_MASK),
        .sel_ack  (1'b0),
        .stat     (sr_stat),
        .en       (sr_en),
        .mask     (sr_mask),
        .req      (susp_irq)
    );

    assign int0_wr_clr = reg_wr && (addr == A_INT0) && reg_wdata[0];

    usb_int0_flag u_int0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (susp_irq),
        .taken  (int0_taken),
        .wr_clr (int0_wr_clr),
        .flag   (int0_flag)
    );

    always_comb begin
        unique case (addr)
            A_FE_STAT: reg_rdata = fe_stat;
            A_FE_EN:   reg_rdata = fe_en;
            A_FE_MASK: reg_rdata = fe_mask;
            A_FE_ACK:  reg_rdata = '0;
            A_SR_STAT: reg_rdata = sr_stat;
            A_SR_EN:   reg_rdata = sr_en;
            A_SR_MASK: reg_rdata = sr_mask;
            A_INT0:    reg_rdata = {{(REG_W-1){1'b0}}, int0_flag};
            default:   reg_rdata = '0;
        endcase
    end

    AST_HW_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hw_irq |-> (fe_stat != '0)); // R5
    AST_SUSP_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        susp_irq |-> ((sr_stat & sr_en) != '0)); // R6
endmodule

// File: tb/usb_irq_agg_tb.sv
module usb_irq_agg_tb;
    localparam int CLK_P = 10;
    localparam int Q     = CLK_P / 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fe_evt = '0;
    logic [2:0] sr_evt = '0;
    logic       int0_taken = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       hw_irq, susp_irq, int0_flag;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // behavioural model state
    bit [7:0] m_fs, m_fe, m_fm, m_ss, m_se, m_sm;
    bit       m_i0;

    always #(CLK_P/2) clk = ~clk;

    usb_irq_agg u_dut (
        .clk(clk), .rst_n(rst_n), .fe_evt(fe_evt), .sr_evt(sr_evt),
        .int0_taken(int0_taken), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_irq(hw_irq),
        .susp_irq(susp_irq), .int0_flag(int0_flag)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] model_rd(logic [2:0] a);
        case (a)
            3'd0: return m_fs;
            3'd1: return m_fe;
            3'd2: return m_fm;
            3'd4: return m_ss;
            3'd5: return m_se;
            3'd6: return m_sm;
            3'd7: return {7'b0, m_i0};
            default: return 8'h00;
        endcase
    endfunction

    // Model: one update per rising edge, bit by bit.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_fs = 0; m_fe = 0; m_fm = 0; m_ss = 0; m_se = 0; m_sm = 0; m_i0 = 0;
        end else begin
            bit sreq;
            sreq = (m_ss & m_se & ~m_sm) != 0;
            for (int i = 0; i < 8; i++) begin
                bit legal_fe, legal_sr;
                legal_fe = (i != 4) && (i != 5);
                legal_sr = (i < 3);
                if (reg_wr && reg_addr == 3'd3 && reg_wdata[i]) m_fs[i] = 0;
                if (fe_evt[i] && legal_fe) m_fs[i] = 1;
                if (reg_wr && reg_addr == 3'd4 && !reg_wdata[i]) m_ss[i] = 0;
                if (legal_sr && sr_evt[i % 3] && i < 3) m_ss[i] = 1;
                if (reg_wr && reg_addr == 3'd1) m_fe[i] = reg_wdata[i] & legal_fe;
                if (reg_wr && reg_addr == 3'd2) m_fm[i] = reg_wdata[i] & legal_fe;
                if (reg_wr && reg_addr == 3'd5) m_se[i] = reg_wdata[i] & legal_sr;
                if (reg_wr && reg_addr == 3'd6) m_sm[i] = reg_wdata[i] & legal_sr;
            end
            if (int0_taken || (reg_wr && reg_addr == 3'd7 && reg_wdata[0])) m_i0 = 0;
            if (sreq) m_i0 = 1;
        end
    end

    // Compare every cycle, half a period after the edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(reg_addr == 3'd3 ? "R3 ack read" : "R10 read data", reg_rdata, model_rd(reg_addr));
            check("R5 hw_irq", {7'b0, hw_irq}, {7'b0, (m_fs & m_fe & ~m_fm) != 0});
            check("R6 susp_irq", {7'b0, susp_irq}, {7'b0, (m_ss & m_se & ~m_sm) != 0});
            check("R7 int0_flag", {7'b0, int0_flag}, {7'b0, m_i0});
        end
    end

    task automatic wr(logic [2:0] a, logic [7:0] v);
        @(posedge clk); #Q;
        reg_addr = a; reg_wr = 1'b1; reg_wdata = v;
        @(posedge clk); #Q;
        reg_wr = 1'b0;
    endtask

    task automatic rd_expect(logic [2:0] a, logic [7:0] exp, string tag);
        reg_addr = a;
        @(negedge clk);
        check(tag, reg_rdata, exp);
    endtask

    task automatic pulse(logic [7:0] f, logic [2:0] s);
        @(posedge clk); #Q;
        fe_evt = f; sr_evt = s;
        @(posedge clk); #Q;
        fe_evt = '0; sr_evt = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        finished = 1;
        summary();
    end

    initial begin
        int lfsr;
        repeat (3) @(posedge clk);
        #Q rst_n = 1'b1;
        // R9: reset state
        for (int a = 0; a < 8; a++) rd_expect(a[2:0], 8'h00, "R9 reset register");
        check("R9 hw_irq after reset", {7'b0, hw_irq}, 8'h00);
        check("R9 int0_flag after reset", {7'b0, int0_flag}, 8'h00);

        // R1: latching, reserved bits zero
        pulse(8'hFF, 3'b000);
        rd_expect(3'd0, 8'hCF, "R1 status latch");
        // R2: writes to status ignored, ack clears
        wr(3'd0, 8'h00);
        rd_expect(3'd0, 8'hCF, "R2 status write ignored");
        wr(3'd3, 8'h81);
        rd_expect(3'd0, 8'h4E, "R2 ack clear");
        // R3
        wr(3'd3, 8'h00);
        rd_expect(3'd3, 8'h00, "R3 ack reads zero");

        // R10 + R5: enable/mask gating
        wr(3'd1, 8'hFF);
        rd_expect(3'd1, 8'hCF, "R10 enable readback");
        check("R5 hw_irq enabled", {7'b0, hw_irq}, 8'h01);
        wr(3'd2, 8'h4E);
        rd_expect(3'd2, 8'h4E, "R10 mask readback");
        check("R5 hw_irq masked", {7'b0, hw_irq}, 8'h00);
        wr(3'd2, 8'h46);
        @(negedge clk);
        check("R5 hw_irq one unmasked", {7'b0, hw_irq}, 8'h01);

        // R8: event same cycle as ack keeps flag
        @(posedge clk); #Q;
        fe_evt = 8'h08; reg_addr = 3'd3; reg_wr = 1'b1; reg_wdata = 8'h08;
        @(posedge clk); #Q;
        fe_evt = '0; reg_wr = 1'b0;
        rd_expect(3'd0, 8'h4E, "R8 fe set beats ack");

        // R4: suspend/resume latching and write-zero clear
        pulse(8'h00, 3'b111);
        rd_expect(3'd4, 8'h07, "R4 sr latch");
        wr(3'd4, 8'hFD);
        rd_expect(3'd4, 8'h05, "R4 write zero clears");
        wr(3'd4, 8'hFF);
        rd_expect(3'd4, 8'h05, "R4 write one no set");
        check("R6 susp_irq disabled", {7'b0, susp_irq}, 8'h00);
        check("R7 int0 idle", {7'b0, int0_flag}, 8'h00);

        // R6/R7: request and latched flag
        wr(3'd6, 8'h00);
        wr(3'd5, 8'hFF);
        rd_expect(3'd5, 8'h07, "R10 sr enable readback");
        check("R6 susp_irq on", {7'b0, susp_irq}, 8'h01);
        @(negedge clk);
        check("R7 int0 set", {7'b0, int0_flag}, 8'h01);
        wr(3'd6, 8'h07);
        check("R6 susp_irq masked", {7'b0, susp_irq}, 8'h00);
        @(posedge clk); #Q int0_taken = 1'b1;
        @(posedge clk); #Q int0_taken = 1'b0;
        rd_expect(3'd7, 8'h00, "R7 taken clears");
        wr(3'd6, 8'h00);
        @(negedge clk);
        wr(3'd6, 8'h07);
        rd_expect(3'd7, 8'h01, "R7 flag set again");
        wr(3'd7, 8'h01);
        rd_expect(3'd7, 8'h00, "R7 write one clears");

        // R8: sr event same cycle as write zero
        @(posedge clk); #Q;
        sr_evt = 3'b010; reg_addr = 3'd4; reg_wr = 1'b1; reg_wdata = 8'h00;
        @(posedge clk); #Q;
        sr_evt = '0; reg_wr = 1'b0;
        rd_expect(3'd4, 8'h02, "R8 sr set beats clear");
        // R8: int0 set beats taken
        wr(3'd6, 8'h00);
        @(negedge clk);
        @(posedge clk); #Q int0_taken = 1'b1;
        @(posedge clk); #Q int0_taken = 1'b0;
        rd_expect(3'd7, 8'h01, "R8 int0 set beats taken");

        // mixed stimulus, model compared every cycle
        lfsr = 32'h1ACE5;
        for (int n = 0; n < 600; n++) begin
            @(posedge clk); #Q;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            fe_evt     = (lfsr[3:0] == 0) ? lfsr[15:8] : 8'h00;
            sr_evt     = (lfsr[7:5] == 0) ? lfsr[18:16] : 3'b000;
            int0_taken = lfsr[22:20] == 0;
            reg_addr   = lfsr[26:24];
            reg_wr     = lfsr[28:27] == 0;
            reg_wdata  = lfsr[31:24] ^ lfsr[11:4];
        end
        @(posedge clk); #Q;
        fe_evt = '0; sr_evt = '0; int0_taken = 1'b0; reg_wr = 1'b0;
        @(negedge clk);
        finished = 1;
        summary();
    end
endmodule